// File: doc/BRIEF.md
# Serial Memory Target Front End for a Two-Wire Bus

This block is the bus-facing half of a 4096-byte serial memory on a two-wire, open-drain bus. It runs entirely in a fast system clock. The clock and data lines are oversampled and synchronized, and start and stop conditions are recognized from them. The block claims its header only when the header carries the fixed device-type nibble `1010` followed by the three strap inputs. It loads a 12-bit word address from two bytes, streams write bytes to a separate page-programming engine, and returns read data from a synchronous memory array that has one cycle of read latency.

Reads come in three forms. A current-address read returns the byte the internal counter points at. A random read first loads the counter with a write-type header and two address bytes, then issues a repeated start with a read header. A sequential read continues for as long as the controller acknowledges. While the programming engine reports a write cycle in progress, the block refuses its own header. A controller can therefore poll with headers until one is acknowledged.

The data line is never driven high. The block only asserts a pull-low enable, and it changes that enable only after it has seen a clock falling edge. The system clock must run at least eight times faster than the bus clock.

Top module: `i2c_mem_target`

## Requirements
- R1: Bus traffic is ignored until a start condition, which is data falling while the clock is high. A stop condition, which is data rising while the clock is high, releases the data line and returns the block to idle.
- R2: Data is sampled on the clock rising edge. The pull-low enable changes only after a clock falling edge, and never while the clock stays high.
- R3: In the header byte, bits 7..4 must equal 1010 and bits 3..1 must equal strap[2:1:0]. Bit 0 selects the direction: 1 for read, 0 for write. A matching header is acknowledged by pulling data low during the 9th clock.
- R4: A header that does not match is not acknowledged. All later bytes up to the next start condition get no acknowledge and produce no write strobe.
- R5: After a write header, two address bytes follow, most significant first. Each is acknowledged. Bits 15..12 are ignored, which leaves a 12-bit address.
- R6: Each data byte after the address bytes is acknowledged and presented on wr_valid with wr_addr and wr_data. Addresses rise by one per byte. A stop that follows at least one data byte pulses wr_done for one cycle.
- R7: While mem_busy is high, the block does not acknowledge a matching header. Once mem_busy falls, the same header is acknowledged.
- R8: A random read, made of a write header, two address bytes, a repeated start and a read header, returns the byte at the loaded address.
- R9: After each read byte the counter points at the next location. A later current-address read therefore continues from there.
- R10: When the controller acknowledges a read byte, the next byte follows. The address wraps from 0xFFF to 0x000.
- R11: When the controller does not acknowledge a read byte, the block releases data and drives nothing until the next start condition.
- R12: After reset the data line is released and wr_valid and wr_done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap | input | 3 | Device-select strap bits compared with header bits 3..1 |
| mem_busy | input | 1 | Programming engine is in a write cycle |
| rd_addr | output | 12 | Address to the synchronous memory array (current counter) |
| rd_data | input | 8 | Array read data, one cycle after rd_addr |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | 12 | Address of the strobed write byte |
| wr_data | output | 8 | Strobed write byte |
| wr_done | output | 1 | One-cycle pulse at a stop that ends a write with data |

## Verification
A wrong frame state shows up on the bus within one byte. The acknowledge appears on the wrong clock or not at all, or data bits arrive shifted, and the bench compares each ninth-clock level against its own expected acknowledge. An address counter that is off by one or wraps wrongly is visible on the very next read byte, because the bench holds its own model of the array contents. A write strobe with a wrong address or data is caught in the cycle it appears, by comparison against a queue of expected bytes.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int ADDR_W       = 12;
    localparam int SYNC_STAGES  = 2;
    localparam logic [3:0] DEV_TYPE = 4'b1010;
    localparam logic [3:0] BIT_ACK  = 4'd8;
    localparam logic [3:0] BIT_END  = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_ADR_HI,
        ST_ADR_LO,
        ST_WDATA,
        ST_RDATA
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    function automatic logic hdr_hit(input logic [7:0] hdr, input logic [2:0] sel);
        return (hdr[7:4] == DEV_TYPE) && (hdr[3:1] == sel);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_mem_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end else begin
                    scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
                    sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_pipe[STAGES-1];
            sda_q <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        ev.sda      = sda_pipe[STAGES-1];
        ev.scl_rise = scl_pipe[STAGES-1] & ~scl_q;
        ev.scl_fall = ~scl_pipe[STAGES-1] & scl_q;
        ev.start    = scl_pipe[STAGES-1] & scl_q & sda_q & ~sda_pipe[STAGES-1];
        ev.stop     = scl_pipe[STAGES-1] & scl_q & ~sda_q & sda_pipe[STAGES-1];
    end

endmodule

// File: rtl/i2c_tgt_addr_ctr.sv
module i2c_tgt_addr_ctr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_hi,
    input  logic          load_lo,
    input  logic          step,
    input  logic [AW-9:0] hi_in,
    input  logic [7:0]    lo_in,
    output logic [AW-1:0] addr
);
    localparam int HI_W = AW - 8;

    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            addr <= '0;
        end else begin
            if (load_hi) hi_q <= hi_in;
            if (load_lo)   addr <= {hi_q, lo_in};
            else if (step) addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mem_pkg::*;
#(
    parameter int AW = i2c_mem_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    input  logic [2:0]    strap,
    input  logic          mem_busy,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          wr_done
);
    localparam int HI_W = AW - 8;

    bus_ev_t    ev;
    tgt_state_e state;
    logic [3:0] bitcnt;
    logic [7:0] rx, tx;
    logic       rw_q, mack, have_data;
    logic       ack_entry, frame_end;
    logic       ld_hi, ld_lo, step;
    logic [AW-1:0] ctr;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    assign ack_entry = ev.scl_fall && (bitcnt == BIT_ACK) && (state != ST_IDLE);
    assign frame_end = ev.scl_fall && (bitcnt == BIT_END) && (state != ST_IDLE);
    assign ld_hi = ack_entry && (state == ST_ADR_HI);
    assign ld_lo = ack_entry && (state == ST_ADR_LO);
    assign step  = (ack_entry && (state == ST_WDATA)) ||
                   (ev.scl_rise && (bitcnt == BIT_ACK) && (state == ST_RDATA));

    i2c_tgt_addr_ctr #(.AW(AW)) u_ctr (
        .clk(clk), .rst(rst), .load_hi(ld_hi), .load_lo(ld_lo), .step(step),
        .hi_in(rx[HI_W-1:0]), .lo_in(rx), .addr(ctr)
    );

    assign rd_addr = ctr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            rx        <= '0;
            tx        <= '0;
            rw_q      <= 1'b0;
            mack      <= 1'b0;
            have_data <= 1'b0;
            sda_oe    <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_done   <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            wr_done  <= 1'b0;
            if (ev.start) begin
                state     <= ST_HDR;
                bitcnt    <= '0;
                sda_oe    <= 1'b0;
                have_data <= 1'b0;
            end else if (ev.stop) begin
                state     <= ST_IDLE;
                sda_oe    <= 1'b0;
                wr_done   <= have_data;
                have_data <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (ev.scl_rise) begin
                    if (bitcnt < BIT_ACK) rx <= {rx[6:0], ev.sda};
                    if (bitcnt == BIT_ACK) mack <= ~ev.sda;
                    if (bitcnt != BIT_END) bitcnt <= bitcnt + 1'b1;
                end else if (ack_entry) begin
                    unique case (state)
                        ST_RDATA: sda_oe <= 1'b0;
                        ST_HDR: begin
                            sda_oe <= hdr_hit(rx, strap) && !mem_busy;
                            rw_q   <= rx[0];
                        end
                        ST_WDATA: begin
                            sda_oe    <= 1'b1;
                            wr_valid  <= 1'b1;
                            wr_addr   <= ctr;
                            wr_data   <= rx;
                            have_data <= 1'b1;
                        end
                        default: sda_oe <= 1'b1;
                    endcase
                end else if (frame_end) begin
                    bitcnt <= '0;
                    sda_oe <= 1'b0;
                    unique case (state)
                        ST_HDR: begin
                            if (!sda_oe) state <= ST_IDLE;
                            else if (rw_q) begin
                                state  <= ST_RDATA;
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else state <= ST_ADR_HI;
                        end
                        ST_ADR_HI: state <= ST_ADR_LO;
                        ST_ADR_LO: state <= ST_WDATA;
                        ST_RDATA: begin
                            if (mack) begin
                                tx     <= rd_data;
                                sda_oe <= ~rd_data[7];
                            end else state <= ST_IDLE;
                        end
                        default: state <= state;
                    endcase
                end else if (ev.scl_fall && (state == ST_RDATA) &&
                             (bitcnt != 4'd0) && (bitcnt < BIT_ACK)) begin
                    sda_oe <= ~tx[~bitcnt[2:0]];
                end
            end
        end
    end

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R4
    AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!ev.scl_fall && !ev.start && !ev.stop) |=> $stable(sda_oe)); // R2
    AST_HDR_ACK_MATCH: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HDR) && $rose(sda_oe)) |-> (rx[7:4] == DEV_TYPE && rx[3:1] == strap)); // R3
    AST_HDR_ACK_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_HDR) && $rose(sda_oe)) |-> !$past(mem_busy)); // R7
    AST_WR_IN_SESSION: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (state == ST_WDATA)); // R6

endmodule

// File: tb/test_i2c_mem_target.sv
module test_i2c_mem_target;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1, m_sda = 1'b1;
    logic sda_oe, wr_valid, wr_done;
    logic [11:0] rd_addr, wr_addr;
    logic [7:0]  rd_data, wr_data;
    logic mem_busy;
    logic [2:0] strap = 3'b101;
    wire  sda_w = m_sda & ~sda_oe;

    int nchk = 0, nfail = 0, ncyc = 0;
    int n_wr_valid = 0, n_wr_done = 0, r2_viol = 0;
    logic [7:0]  mem [4096];
    logic [7:0]  ref_mem [4096];
    logic [19:0] expq [$];
    logic [19:0] pend [$];
    int busy_cnt = 0;
    logic prev_scl = 1'b1, prev_oe = 1'b0;

    always #4 clk = ~clk;

    i2c_mem_target i_i2c_mem_target (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_w), .sda_oe(sda_oe),
        .strap(strap), .mem_busy(mem_busy), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_done(wr_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        chk("R2 enable stable while clock high", r2_viol, 0);
        chk("R6 all expected writes seen", expq.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // Simple programming engine and synchronous array model.
    always @(posedge clk) begin
        rd_data <= mem[rd_addr];
        if (rst) begin
            busy_cnt = 0;
        end else begin
            if (wr_valid) pend.push_back({wr_addr, wr_data});
            if (wr_done) begin
                while (pend.size() > 0) begin
                    logic [19:0] e;
                    e = pend.pop_front();
                    mem[e[19:8]] = e[7:0];
                end
                busy_cnt = 200;
            end else if (busy_cnt != 0) busy_cnt = busy_cnt - 1;
        end
        mem_busy <= (busy_cnt != 0);
    end

    // Per-clock comparison against the behavioural model.
    always @(negedge clk) begin
        ncyc++;
        if (!rst) begin
            if (wr_valid) begin
                n_wr_valid++;
                if (expq.size() == 0) chk("R6 unexpected write strobe", 1, 0);
                else begin
                    logic [19:0] e;
                    e = expq.pop_front();
                    chk("R6 write strobe addr/data", {wr_addr, wr_data}, e);
                end
            end
            if (wr_done) n_wr_done++;
            if (scl && prev_scl && (sda_oe !== prev_oe)) r2_viol++;
        end
        prev_scl = scl;
        prev_oe  = sda_oe;
        if (ncyc > 150000) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=%0d expected=<150000", ncyc);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic seen);
        tick(5); m_sda = b; tick(3); scl = 1'b1; tick(4); seen = sda_w; tick(4); scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(2); m_sda = 1'b1; tick(6); scl = 1'b1; tick(4); m_sda = 1'b0; tick(4); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(5); m_sda = 1'b0; tick(3); scl = 1'b1; tick(4); m_sda = 1'b1; tick(8);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_io(b[i], s);
        bit_io(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_io(1'b1, s);
            b[i] = s;
        end
        bit_io(~give_ack, s);
    endtask

    localparam logic [7:0] HDR_W = {4'b1010, 3'b101, 1'b0};
    localparam logic [7:0] HDR_R = {4'b1010, 3'b101, 1'b1};

    initial begin
        logic a;
        logic [7:0] d;
        int polls, wv0;
        for (int i = 0; i < 4096; i++) begin
            mem[i]     = 8'(i * 37 + 5);
            ref_mem[i] = 8'(i * 37 + 5);
        end
        tick(4);
        rst = 1'b0;
        tick(1);
        chk("R12 sda_oe after reset", sda_oe, 0);
        chk("R12 wr_valid after reset", wr_valid, 0);
        chk("R12 wr_done after reset", wr_done, 0);

        // R1: a valid header clocked without a start is ignored
        tick(4); scl = 1'b0;
        send_byte(HDR_R, a);
        chk("R1 no ack without start", a, 0);
        bus_stop();

        // R3 R5 R6: byte write at 0x123, top nibble of address set
        bus_start();
        send_byte(HDR_W, a); chk("R3 write header acked", a, 1);
        send_byte(8'hF1, a); chk("R5 high address byte acked", a, 1);
        send_byte(8'h23, a); chk("R5 low address byte acked", a, 1);
        expq.push_back({12'h123, 8'hA5}); ref_mem[12'h123] = 8'hA5;
        send_byte(8'hA5, a); chk("R6 data byte acked", a, 1);
        bus_stop();
        tick(2);
        chk("R6 one commit pulse", n_wr_done, 1);

        // R7: busy refuses header, polling finally succeeds
        bus_start();
        send_byte(HDR_W, a); chk("R7 header refused while busy", a, 0);
        bus_stop();
        polls = 0;
        do begin
            bus_start();
            send_byte(HDR_W, a);
            polls++;
            if (!a) bus_stop();
        end while (!a && polls < 20);
        chk("R7 header acked after busy", a, 1);
        // R8: random read from 0x123
        send_byte(8'h01, a); chk("R5 address byte acked", a, 1);
        send_byte(8'h23, a); chk("R5 address byte acked", a, 1);
        bus_start();
        send_byte(HDR_R, a); chk("R3 read header acked", a, 1);
        recv_byte(1'b0, d); chk("R8 random read data", d, ref_mem[12'h123]);
        bus_stop();

        // R9: current-address read continues at next location
        bus_start();
        send_byte(HDR_R, a); chk("R3 read header acked", a, 1);
        recv_byte(1'b0, d); chk("R9 current address read", d, ref_mem[12'h124]);
        bus_stop();

        // R10: sequential read across the top of memory
        bus_start();
        send_byte(HDR_W, a);
        send_byte(8'h0F, a);
        send_byte(8'hFE, a); chk("R5 address byte acked", a, 1);
        bus_start();
        send_byte(HDR_R, a);
        recv_byte(1'b1, d); chk("R10 sequential byte 0xFFE", d, ref_mem[12'hFFE]);
        recv_byte(1'b1, d); chk("R10 sequential byte 0xFFF", d, ref_mem[12'hFFF]);
        recv_byte(1'b0, d); chk("R10 wrapped to 0x000", d, ref_mem[12'h000]);
        // R11: after NACK the block drives nothing
        recv_byte(1'b0, d); chk("R11 released after nack", d, 8'hFF);
        bus_stop();
        bus_start();
        send_byte(HDR_R, a);
        recv_byte(1'b0, d); chk("R9 counter after wrap", d, ref_mem[12'h001]);
        bus_stop();

        // R4: strap mismatch and type mismatch
        wv0 = n_wr_valid;
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, a); chk("R4 strap mismatch nacked", a, 0);
        send_byte(8'h00, a); chk("R4 later byte ignored", a, 0);
        send_byte(8'h55, a); chk("R4 later byte ignored", a, 0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, 3'b101, 1'b1}, a); chk("R3 type mismatch nacked", a, 0);
        bus_stop();
        tick(2);
        chk("R4 no write strobe", n_wr_valid, wv0);

        // R6: page write of three bytes crossing 0x7FF
        bus_start();
        send_byte(HDR_W, a);
        send_byte(8'h07, a);
        send_byte(8'hFE, a);
        for (int i = 0; i < 3; i++) begin
            logic [11:0] ad;
            ad = 12'h7FE + 12'(i);
            expq.push_back({ad, 8'(8'h11 * (i + 1))});
            ref_mem[ad] = 8'(8'h11 * (i + 1));
            send_byte(8'(8'h11 * (i + 1)), a); chk("R6 page byte acked", a, 1);
        end
        bus_stop();
        tick(300);
        bus_start();
        send_byte(HDR_W, a);
        send_byte(8'h07, a);
        send_byte(8'hFF, a);
        bus_start();
        send_byte(HDR_R, a);
        recv_byte(1'b1, d); chk("R6 page byte at 0x7FF", d, ref_mem[12'h7FF]);
        recv_byte(1'b0, d); chk("R6 page byte at 0x800", d, ref_mem[12'h800]);
        bus_stop();
        tick(2);
        chk("R1 released after stop", sda_oe, 0);
        finish_run();
    end

endmodule